// File: doc/BRIEF.md
# Runtime-Configurable Sum-of-Products Array

This block is a small programmable logic array held in registers rather than fuses. A fixed set of product terms forms AND combinations of the data inputs. A second plane of connection bits routes any subset of those terms into each output, and each output is the OR of its connected terms. The result is a two-level sum-of-products function. It can be reloaded at any time without touching the datapath.

Each term owns one configuration word pair. The AND word holds a 2-bit code for every input, and the OR word holds one bit for every output. A synchronous write port loads one term per clock. The outputs are pure combinational logic of the data inputs and the stored configuration, so a loaded function answers within the same cycle the inputs change. A single term may feed several outputs at once, which lets common products be shared instead of repeated.

Top module: `pla_core`

## Requirements
- R1: An input whose 2-bit code is 01 (code of input i sits at AND-word bits [2i+1:2i]) enters its term uncomplemented: the term is 1 only when that input is 1.
- R2: An input whose code is 10 enters its term complemented: the term is 1 only when that input is 0.
- R3: An input whose code is 00 does not take part, and a term whose codes are all 00 evaluates to 1 for every input value.
- R4: Any code of 11 in a term forces that term to 0 whatever the inputs.
- R5: Output o is the OR of every term whose OR-word bit o is 1. An output with no connected term is 0.
- R6: One term with several OR-word bits set drives all of those outputs at the same time.
- R7: When the write enable is high at a rising clock edge, the AND and OR words are stored for the indexed term and act from that edge on. Before that edge the old function holds. With the write enable low, the word inputs have no effect.
- R8: A synchronous active-high reset clears every AND and OR word, so every output reads 0 for all inputs. Reset takes priority over a write in the same cycle.
- R9: With the terms AB, B'C, AC', B'C' and A loaded and shared as needed (A, B, C on inputs 0, 1, 2), the outputs give F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A for all input values.
- R10: A write to one term index leaves the configuration of every other term unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset; clears all configuration |
| cfg_we | input | 1 | Configuration write enable |
| cfg_term_idx | input | TIDX_W (3) | Index of the term being written |
| cfg_and_word | input | 2*N_IN (8) | Literal codes for the indexed term, 2 bits per input |
| cfg_or_word | input | N_OUT (4) | Term-to-output connection bits for the indexed term |
| data_in | input | N_IN (4) | Data inputs of the array |
| data_out | output | N_OUT (4) | Combinational sum-of-products outputs |

## Verification
Each configuration is checked against all sixteen input values. Single-literal configurations separate the true, complemented, absent and kill codes from one another. The example function set is checked by direct formulas, which shows whether shared terms reach every output they should. Pseudo-random fills of all terms mix every code in every position, and so catch wrong bit positions or crossed term indices. Probes just before and just after a write edge show when a new word takes effect. A sweep after a write with the enable low, or after a reset, shows that the old configuration was kept or that all of it was cleared.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // 2-bit literal code per input inside a product term
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,  // input ignored
    LIT_POS  = 2'b01,  // input used as is
    LIT_NEG  = 2'b10,  // input used inverted
    LIT_KILL = 2'b11   // term forced low
  } lit_e;

  localparam int LIT_W = 2;

  // Contribution of one literal to its product term
  function automatic logic lit_pass(input logic [LIT_W-1:0] code, input logic bit_v);
    logic r;
    unique case (lit_e'(code))
      LIT_OFF:  r = 1'b1;
      LIT_POS:  r = bit_v;
      LIT_NEG:  r = ~bit_v;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  localparam int AW     = LIT_W * N_IN,
  localparam int TIDX_W = idx_width(N_TERM)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [TIDX_W-1:0]       idx,
  input  logic [AW-1:0]           and_word,
  input  logic [N_OUT-1:0]        or_word,
  output logic [N_TERM*AW-1:0]    and_flat,
  output logic [N_TERM*N_OUT-1:0] or_flat
);

  // One register pair per term; all are read in parallel by the planes.
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [AW-1:0]    and_q;
    logic [N_OUT-1:0] or_q;
    logic             hit;

    assign hit = we && (idx == TIDX_W'(t));

    always_ff @(posedge clk) begin
      if (rst) begin
        and_q <= '0;
        or_q  <= '0;
      end else if (hit) begin
        and_q <= and_word;
        or_q  <= or_word;
      end
    end

    assign and_flat[t*AW +: AW]       = and_q;
    assign or_flat[t*N_OUT +: N_OUT]  = or_q;
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  localparam int AW    = LIT_W * N_IN
) (
  input  logic [N_IN-1:0]      data_in,
  input  logic [N_TERM*AW-1:0] and_flat,
  output logic [N_TERM-1:0]    term_vec
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] pass;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign pass[i] = lit_pass(and_flat[t*AW + i*LIT_W +: LIT_W], data_in[i]);
    end
    // Empty product (all absent) is the AND identity: 1
    assign term_vec[t] = &pass;
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4
) (
  input  logic [N_TERM-1:0]       term_vec,
  input  logic [N_TERM*N_OUT-1:0] or_flat,
  output logic [N_OUT-1:0]        data_out
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel;
    for (genvar t = 0; t < N_TERM; t++) begin : g_sel
      assign sel[t] = term_vec[t] & or_flat[t*N_OUT + o];
    end
    // Empty sum is the OR identity: 0
    assign data_out[o] = |sel;
  end

endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  localparam int AW     = LIT_W * N_IN,
  localparam int TIDX_W = idx_width(N_TERM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [TIDX_W-1:0] cfg_term_idx,
  input  logic [AW-1:0]     cfg_and_word,
  input  logic [N_OUT-1:0]  cfg_or_word,
  input  logic [N_IN-1:0]   data_in,
  output logic [N_OUT-1:0]  data_out
);

  logic [N_TERM*AW-1:0]    and_flat;
  logic [N_TERM*N_OUT-1:0] or_flat;
  logic [N_TERM-1:0]       term_vec;

  pla_cfg_store #(
    .N_IN  (N_IN),
    .N_TERM(N_TERM),
    .N_OUT (N_OUT)
  ) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .idx     (cfg_term_idx),
    .and_word(cfg_and_word),
    .or_word (cfg_or_word),
    .and_flat(and_flat),
    .or_flat (or_flat)
  );

  pla_and_plane #(
    .N_IN  (N_IN),
    .N_TERM(N_TERM)
  ) and_i (
    .data_in (data_in),
    .and_flat(and_flat),
    .term_vec(term_vec)
  );

  pla_or_plane #(
    .N_TERM(N_TERM),
    .N_OUT (N_OUT)
  ) or_i (
    .term_vec(term_vec),
    .or_flat (or_flat),
    .data_out(data_out)
  );

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  localparam int AW     = LIT_W * N_IN,
  localparam int TIDX_W = idx_width(N_TERM)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [TIDX_W-1:0]    cfg_term_idx,
  input logic [AW-1:0]        cfg_and_word,
  input logic [N_OUT-1:0]     data_out,
  input logic [N_TERM*AW-1:0] and_flat,
  input logic [N_TERM-1:0]    term_vec
);

  logic              last_we;
  logic [TIDX_W-1:0] last_idx;
  logic [AW-1:0]     last_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_we   <= 1'b0;
      last_idx  <= '0;
      last_word <= '0;
    end else begin
      last_we   <= cfg_we && (int'(cfg_term_idx) < N_TERM);
      last_idx  <= cfg_term_idx;
      last_word <= cfg_and_word;
    end
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (data_out == '0));

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    last_we |-> (and_flat[int'(last_idx)*AW +: AW] == last_word));

  // R7
  hold_no_we_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && !$past(rst)) |-> $stable(and_flat));

  // R5
  no_term_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (term_vec == '0) |-> (data_out == '0));

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    logic [N_IN-1:0] kill;
    for (genvar i = 0; i < N_IN; i++) begin : g_i
      assign kill[i] = (and_flat[t*AW + i*LIT_W +: LIT_W] == 2'b11);
    end
    // R4
    kill_term_chk: assert property (@(posedge clk) disable iff (rst)
      (kill != '0) |-> !term_vec[t]);
    // R3
    empty_term_chk: assert property (@(posedge clk) disable iff (rst)
      (and_flat[t*AW +: AW] == '0) |-> term_vec[t]);
  end

endmodule

bind pla_core pla_core_chk #(
  .N_IN  (N_IN),
  .N_TERM(N_TERM),
  .N_OUT (N_OUT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_term_idx(cfg_term_idx),
  .cfg_and_word(cfg_and_word),
  .data_out    (data_out),
  .and_flat    (and_flat),
  .term_vec    (term_vec)
);

// File: tb/pla_core_tb_top.sv
`timescale 1ns/1ps
module pla_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_term_idx = '0;
  logic [7:0] cfg_and_word = '0;
  logic [3:0] cfg_or_word = '0;
  logic [3:0] data_in = '0;
  logic [3:0] data_out;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [7:0]  m_and [8];
  logic [3:0]  m_or  [8];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  pla_core dut_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_term_idx(cfg_term_idx),
    .cfg_and_word(cfg_and_word),
    .cfg_or_word (cfg_or_word),
    .data_in     (data_in),
    .data_out    (data_out)
  );

  function automatic logic [3:0] model(input logic [3:0] d);
    logic [3:0] r = '0;
    for (int t = 0; t < 8; t++) begin
      logic tv = 1'b1;
      for (int i = 0; i < 4; i++) begin
        case (m_and[t][2*i +: 2])
          2'b00: ;
          2'b01: if (!d[i]) tv = 1'b0;
          2'b10: if (d[i])  tv = 1'b0;
          default: tv = 1'b0;
        endcase
      end
      if (tv) r = r | m_or[t];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s data_in=%h actual=%h expected=%h", req, data_in, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int t = 0; t < 8; t++) begin
      m_and[t] = '0;
      m_or[t]  = '0;
    end
  endtask

  task automatic wr(input int t, input logic [7:0] a, input logic [3:0] o);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_term_idx = 3'(t);
    cfg_and_word = a;
    cfg_or_word = o;
    @(negedge clk);
    cfg_we = 1'b0;
    m_and[t] = a;
    m_or[t] = o;
  endtask

  task automatic sweep(input string req);
    for (int d = 0; d < 16; d++) begin
      data_in = 4'(d);
      #0.5;
      chk(req, data_out, model(4'(d)));
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cfg_we = 1'b1;           // R8: reset wins over a concurrent write
    cfg_term_idx = 3'd2;
    cfg_and_word = 8'h00;
    cfg_or_word = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cfg_we = 1'b0;
    clear_model();
  endtask

  initial begin
    clear_model();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R8: cleared after power-up reset
    for (int d = 0; d < 16; d++) begin
      data_in = 4'(d);
      #0.5;
      chk("R8 reset", data_out, 4'h0);
    end

    // R1: term0 = input0 true, to output 0
    wr(0, 8'b00_00_00_01, 4'b0001);
    sweep("R1 true literal");
    // R2: term0 = input0 complemented
    wr(0, 8'b00_00_00_10, 4'b0001);
    sweep("R2 complemented literal");
    // R3: term1 all absent -> output1 constant 1
    wr(1, 8'h00, 4'b0010);
    sweep("R3 absent literals");
    // R4: term1 with a kill code on input2
    wr(1, 8'b00_11_00_00, 4'b0010);
    sweep("R4 kill code");
    // R5: output with no terms stays 0
    wr(0, 8'h00, 4'b0000);
    wr(1, 8'h00, 4'b0000);
    sweep("R5 empty sum");

    // R9 / R6: example function set, A=in0 B=in1 C=in2
    wr(0, 8'h05, 4'b0110);   // AB   -> F1,F2
    wr(1, 8'h18, 4'b1000);   // B'C  -> F3
    wr(2, 8'h21, 4'b0010);   // AC'  -> F1
    wr(3, 8'h28, 4'b0101);   // B'C' -> F0,F2
    wr(4, 8'h01, 4'b1001);   // A    -> F0,F3
    for (int d = 0; d < 16; d++) begin
      logic a, b, c;
      logic [3:0] f;
      a = d[0]; b = d[1]; c = d[2];
      f[0] = a | (~b & ~c);
      f[1] = (a & ~c) | (a & b);
      f[2] = (~b & ~c) | (a & b);
      f[3] = (~b & c) | a;
      data_in = 4'(d);
      #0.5;
      chk("R9 example / R6 shared terms", data_out, f);
    end

    // R7: word inputs ignored while enable is low
    @(negedge clk);
    cfg_term_idx = 3'd0;
    cfg_and_word = 8'h00;
    cfg_or_word = 4'hF;
    repeat (3) @(negedge clk);
    sweep("R7 no enable");

    // R7: effect appears at the write edge, not before
    @(negedge clk);
    data_in = 4'h0;
    cfg_we = 1'b1;
    cfg_term_idx = 3'd5;
    cfg_and_word = 8'h00;
    cfg_or_word = 4'b0010;
    #0.5;
    chk("R7 before edge", data_out, model(4'h0));
    @(posedge clk);
    #0.5;
    m_and[5] = 8'h00;
    m_or[5] = 4'b0010;
    chk("R7 after edge", data_out, model(4'h0));
    @(negedge clk);
    cfg_we = 1'b0;

    // R10: rewriting term 5 keeps the others
    wr(5, 8'b00_00_00_10, 4'b1000);
    sweep("R10 other terms kept");

    // R5 / R6: pseudo-random fills of all terms
    for (int round = 0; round < 6; round++) begin
      for (int t = 0; t < 8; t++) begin
        logic [7:0] aw;
        step_lfsr();
        aw = lfsr[7:0];
        if (round < 3) aw = aw & ~(aw >> 1) & 8'h55 | (aw & ~(aw << 1) & 8'hAA);
        step_lfsr();
        wr(t, aw, lfsr[3:0]);
      end
      sweep("R5 random fill");
    end

    // R8: reset mid-run clears everything
    do_reset();
    for (int d = 0; d < 16; d++) begin
      data_in = 4'(d);
      #0.5;
      chk("R8 mid-run reset", data_out, 4'h0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule